// File: doc/BRIEF.md
# Link wakeup and power controller

This block is the device-side controller that brings a serial ATA link up and takes it into and out of low power. The out-of-band detector reports host reset and host wakeup signals as one-cycle strobes. The controller answers a host reset with a burst train of its own initialisation signal. It answers a host wakeup with a wakeup burst train. It then waits a bounded time for the host's alignment primitives before it declares the link ready for the layer above.

While the link is ready, a decoded power-management request makes the controller send a short run of acknowledge primitives. It then forces the transmit driver idle and raises a low-power flag. Only the host can end low power, either with a new wakeup train or with a reset. A host reset is honoured in every state and always restarts bring-up from the beginning.

The burst and gap lengths, the number of bursts per train, the alignment timeout and the length of the acknowledge run are all parameters. Analog detection, burst shaping, clocking and line coding lie outside the block and reach it only as strobes.

Top module: `link_pwr_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, every output is low and the controller listens for a host reset or wakeup.
- R2: A `comreset_det` strobe starts an initialisation train on `cominit_req` from the next cycle. The train is NUM_BURSTS bursts, each BURST_LEN cycles high followed by GAP_LEN cycles low. After the train the controller listens again.
- R3: A `comwake_det` strobe while listening or in low power starts a wakeup train on `comwake_req` with the same burst timing. `cominit_req` and `comwake_req` are never high together.
- R4: After the wakeup train ends, a sampled `align_det` raises `link_ready` in the next cycle. `link_ready` is high only in this ready state.
- R5: If `align_det` is not seen within ALIGN_TMO cycles after the wakeup train, the controller goes back to listening with `link_ready` low.
- R6: A `pmreq_det` strobe while ready drops `link_ready` and drives `pmack_send` high for exactly ACK_PRIMS consecutive cycles.
- R7: Right after the acknowledge run, `tx_idle` and `low_power` go high. They stay high until the host sends a wakeup or a reset.
- R8: In low power, `pmreq_det` and `align_det` have no effect: `low_power` stays high and no train starts.
- R9: A `comreset_det` strobe in any state, low power included, lowers `link_ready`, `pmack_send`, `tx_idle` and `low_power` and restarts the initialisation train in the next cycle.
- R10: `pmreq_det` outside the ready state is ignored. `comwake_det` during a train, while waiting for alignment or while ready is ignored.
- R11: When `comreset_det` and `comwake_det` arrive in the same cycle, the reset wins and only an initialisation train starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comreset_det | input | 1 | Host reset signal detected (strobe) |
| comwake_det | input | 1 | Host wakeup signal detected (strobe) |
| align_det | input | 1 | Alignment primitive received |
| pmreq_det | input | 1 | Power-management request primitive received (strobe) |
| cominit_req | output | 1 | High while an initialisation burst is to be driven |
| comwake_req | output | 1 | High while a wakeup burst is to be driven |
| pmack_send | output | 1 | Send a power-management acknowledge primitive this cycle |
| tx_idle | output | 1 | Force the transmit driver idle |
| low_power | output | 1 | Link is in the low-power state |
| link_ready | output | 1 | Link is up and aligned |

## Verification
The bench builds the block with BURST_LEN=3, GAP_LEN=5, NUM_BURSTS=6, ALIGN_TMO=20 and ACK_PRIMS=4. With these values a whole 48-cycle train, a timeout expiry and an acknowledge run each fit in a few dozen cycles. Every burst edge, the final gap boundary and the last timeout cycle can therefore be compared cycle by cycle against the reference model. The short trains also leave room to inject a reset in the middle of a wakeup train, during the acknowledge run and in low power within one short run.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN     = 3'd0,
    ST_INIT_TX    = 3'd1,
    ST_WAKE_TX    = 3'd2,
    ST_WAIT_ALIGN = 3'd3,
    ST_READY      = 3'd4,
    ST_PM_ACK     = 3'd5,
    ST_LOW_PWR    = 3'd6
  } lpc_state_e;
endpackage

// File: rtl/lpc_oob_seq.sv
// Out-of-band burst train generator: NUM_BURSTS x (BURST_LEN on, GAP_LEN off).
module lpc_oob_seq #(
  parameter int BURST_LEN  = 16,
  parameter int GAP_LEN    = 48,
  parameter int NUM_BURSTS = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start_init,
  input  logic start_wake,
  output logic init_o,
  output logic wake_o,
  output logic last_o
);
  localparam int LEN_MAX = (BURST_LEN > GAP_LEN) ? BURST_LEN : GAP_LEN;
  localparam int CW      = $clog2(LEN_MAX + 1);
  localparam int IW      = $clog2(NUM_BURSTS + 1);

  logic          active;
  logic          kind_wake;
  logic          in_gap;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  assign last_o = active && in_gap && (cnt == CW'(GAP_LEN - 1)) &&
                  (idx == IW'(NUM_BURSTS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      kind_wake <= 1'b0;
      in_gap    <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
      init_o    <= 1'b0;
      wake_o    <= 1'b0;
    end else if (start_init || start_wake) begin
      active    <= 1'b1;
      kind_wake <= !start_init;
      in_gap    <= 1'b0;
      cnt       <= '0;
      idx       <= '0;
      init_o    <= start_init;
      wake_o    <= !start_init;
    end else if (active) begin
      if (!in_gap) begin
        if (cnt == CW'(BURST_LEN - 1)) begin
          in_gap <= 1'b1;
          cnt    <= '0;
          init_o <= 1'b0;
          wake_o <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (cnt == CW'(GAP_LEN - 1)) begin
        cnt <= '0;
        if (idx == IW'(NUM_BURSTS - 1)) begin
          active <= 1'b0;
        end else begin
          idx    <= idx + 1'b1;
          in_gap <= 1'b0;
          init_o <= !kind_wake;
          wake_o <= kind_wake;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: the two train outputs never overlap
  p_single_kind_r3: assert property (@(posedge clk) disable iff (rst)
    !(init_o && wake_o));
endmodule

// File: rtl/lpc_cycle_timer.sv
// Counts cycles while run is high; last_o marks the LIMIT-th cycle.
module lpc_cycle_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic last_o
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign last_o = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || last_o) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  // R5: the window counter never passes its limit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt < TW'(LIMIT));
endmodule

// File: rtl/lpc_ctrl_fsm.sv
module lpc_ctrl_fsm
  import lpc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic comreset_det,
  input  logic comwake_det,
  input  logic align_det,
  input  logic pmreq_det,
  input  logic seq_last,
  input  logic tmo_last,
  input  logic ack_last,
  output logic start_init,
  output logic start_wake,
  output logic align_run,
  output logic ack_run,
  output logic link_ready,
  output logic pmack_send,
  output logic tx_idle,
  output logic low_power
);
  lpc_state_e state, nxt;

  assign start_init = comreset_det;
  assign start_wake = !comreset_det && comwake_det &&
                      (state == ST_LISTEN || state == ST_LOW_PWR);
  assign align_run  = (state == ST_WAIT_ALIGN);
  assign ack_run    = (state == ST_PM_ACK);

  always_comb begin
    nxt = state;
    if (comreset_det) begin
      nxt = ST_INIT_TX;
    end else begin
      case (state)
        ST_LISTEN:     if (comwake_det) nxt = ST_WAKE_TX;
        ST_INIT_TX:    if (seq_last) nxt = ST_LISTEN;
        ST_WAKE_TX:    if (seq_last) nxt = ST_WAIT_ALIGN;
        ST_WAIT_ALIGN: begin
          if (align_det)     nxt = ST_READY;
          else if (tmo_last) nxt = ST_LISTEN;
        end
        ST_READY:      if (pmreq_det) nxt = ST_PM_ACK;
        ST_PM_ACK:     if (ack_last) nxt = ST_LOW_PWR;
        ST_LOW_PWR:    if (comwake_det) nxt = ST_WAKE_TX;
        default:       nxt = ST_LISTEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_LISTEN;
      link_ready <= 1'b0;
      pmack_send <= 1'b0;
      tx_idle    <= 1'b0;
      low_power  <= 1'b0;
    end else begin
      state      <= nxt;
      link_ready <= (nxt == ST_READY);
      pmack_send <= (nxt == ST_PM_ACK);
      tx_idle    <= (nxt == ST_LOW_PWR);
      low_power  <= (nxt == ST_LOW_PWR);
    end
  end

  // R4: readiness only follows a received alignment
  p_ready_needs_align_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(link_ready) |-> $past(align_det));
  // R6: acknowledge starts only from the ready state
  p_ack_from_ready_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pmack_send) |-> $past(link_ready));
  // R7: low power is entered only straight after the acknowledge run
  p_low_after_ack_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(low_power) |-> $past(pmack_send));
  // R8: no local event leaves low power
  p_low_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (low_power && !comreset_det && !comwake_det) |=> low_power);
  // R9: host reset always drops readiness
  p_reset_drops_ready_r9: assert property (@(posedge clk) disable iff (rst)
    comreset_det |=> (!link_ready && !low_power && !pmack_send));
endmodule

// File: rtl/link_pwr_ctrl.sv
module link_pwr_ctrl #(
  parameter int BURST_LEN  = 16,
  parameter int GAP_LEN    = 48,
  parameter int NUM_BURSTS = 6,
  parameter int ALIGN_TMO  = 1024,
  parameter int ACK_PRIMS  = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic comreset_det,
  input  logic comwake_det,
  input  logic align_det,
  input  logic pmreq_det,
  output logic cominit_req,
  output logic comwake_req,
  output logic pmack_send,
  output logic tx_idle,
  output logic low_power,
  output logic link_ready
);
  logic start_init, start_wake, seq_last;
  logic align_run, tmo_last, ack_run, ack_last;

  lpc_ctrl_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .comreset_det (comreset_det),
    .comwake_det  (comwake_det),
    .align_det    (align_det),
    .pmreq_det    (pmreq_det),
    .seq_last     (seq_last),
    .tmo_last     (tmo_last),
    .ack_last     (ack_last),
    .start_init   (start_init),
    .start_wake   (start_wake),
    .align_run    (align_run),
    .ack_run      (ack_run),
    .link_ready   (link_ready),
    .pmack_send   (pmack_send),
    .tx_idle      (tx_idle),
    .low_power    (low_power)
  );

  lpc_oob_seq #(
    .BURST_LEN  (BURST_LEN),
    .GAP_LEN    (GAP_LEN),
    .NUM_BURSTS (NUM_BURSTS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start_init (start_init),
    .start_wake (start_wake),
    .init_o     (cominit_req),
    .wake_o     (comwake_req),
    .last_o     (seq_last)
  );

  lpc_cycle_timer #(.LIMIT(ALIGN_TMO)) u_align_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (align_run),
    .last_o (tmo_last)
  );

  lpc_cycle_timer #(.LIMIT(ACK_PRIMS)) u_ack_tmr (
    .clk    (clk),
    .rst    (rst),
    .run    (ack_run),
    .last_o (ack_last)
  );

  // R2: every host reset is answered by an initialisation burst next cycle
  p_cominit_answer_r2: assert property (@(posedge clk) disable iff (rst)
    comreset_det |=> (cominit_req && !comwake_req));
endmodule

// File: tb/link_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module link_pwr_ctrl_tb;
  localparam int BL = 3, GL = 5, NB = 6, TMO = 20, ACK = 4;
  localparam int PER = BL + GL;
  localparam int SEQ = NB * PER;

  logic clk = 1'b0, rst = 1'b1;
  logic comreset_det = 0, comwake_det = 0, align_det = 0, pmreq_det = 0;
  logic cominit_req, comwake_req, pmack_send, tx_idle, low_power, link_ready;

  always #2 clk = ~clk;

  link_pwr_ctrl #(.BURST_LEN(BL), .GAP_LEN(GL), .NUM_BURSTS(NB),
                  .ALIGN_TMO(TMO), .ACK_PRIMS(ACK)) u_dut (
    .clk(clk), .rst(rst), .comreset_det(comreset_det), .comwake_det(comwake_det),
    .align_det(align_det), .pmreq_det(pmreq_det), .cominit_req(cominit_req),
    .comwake_req(comwake_req), .pmack_send(pmack_send), .tx_idle(tx_idle),
    .low_power(low_power), .link_ready(link_ready));

  int checks = 0, errors = 0;
  string phase = "R1";
  bit model_on = 0;

  // Behavioural reference: 0 listen,1 init,2 wake,3 align wait,4 ready,5 ack,6 low
  int ms = 0, t = 0, n = 0;

  always @(posedge clk) begin
    model_on = 1;
    if (rst) begin
      ms = 0; t = 0; n = 0;
    end else if (comreset_det) begin
      ms = 1; t = 0;
    end else begin
      case (ms)
        0: if (comwake_det) begin ms = 2; t = 0; end
        1: if (t == SEQ - 1) ms = 0; else t++;
        2: if (t == SEQ - 1) begin ms = 3; n = 0; end else t++;
        3: if (align_det) ms = 4; else if (n == TMO - 1) ms = 0; else n++;
        4: if (pmreq_det) begin ms = 5; n = 0; end
        5: if (n == ACK - 1) ms = 6; else n++;
        6: if (comwake_det) begin ms = 2; t = 0; end
        default: ms = 0;
      endcase
    end
  end

  task automatic chk(string req, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%b expected=%b at %0t", req, phase, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk("R2", cominit_req, (ms == 1) && ((t % PER) < BL), "cominit_req");
      chk("R3", comwake_req, (ms == 2) && ((t % PER) < BL), "comwake_req");
      chk("R4", link_ready, ms == 4, "link_ready");
      chk("R6", pmack_send, ms == 5, "pmack_send");
      chk("R7", tx_idle, ms == 6, "tx_idle");
      chk("R7", low_power, ms == 6, "low_power");
    end
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: comreset_det = 1;
      1: comwake_det = 1;
      2: pmreq_det = 1;
      default: begin comreset_det = 1; comwake_det = 1; end
    endcase
    @(negedge clk);
    comreset_det = 0; comwake_det = 0; pmreq_det = 0;
  endtask

  task automatic bring_up(input bit with_reset);
    if (with_reset) begin pulse(0); cyc(SEQ + 2); end
    pulse(1); cyc(SEQ - 1);
    align_det = 1; cyc(3); align_det = 0;
  endtask

  initial begin
    cyc(3);
    phase = "R1";
    chk("R1", cominit_req | comwake_req | link_ready | low_power | tx_idle | pmack_send,
        1'b0, "outputs in reset");
    rst = 0;
    cyc(1);
    chk("R1", link_ready | cominit_req, 1'b0, "after reset");

    phase = "R10"; pulse(2); cyc(2);
    chk("R10", pmack_send, 1'b0, "pmreq while listening");

    phase = "R2"; pulse(0);
    chk("R2", cominit_req, 1'b1, "first burst");
    phase = "R10"; pulse(1); cyc(SEQ);
    chk("R10", comwake_req, 1'b0, "comwake during init train");

    phase = "R4"; bring_up(0);
    chk("R4", link_ready, 1'b1, "ready after align");
    phase = "R10"; pulse(1); cyc(2);
    chk("R10", comwake_req, 1'b0, "comwake while ready");

    phase = "R6"; pulse(2);
    chk("R6", pmack_send, 1'b1, "ack starts");
    chk("R6", link_ready, 1'b0, "ready dropped");
    cyc(ACK);
    chk("R7", low_power, 1'b1, "low power entered");

    phase = "R8";
    align_det = 1; pulse(2); cyc(10); align_det = 0; cyc(2);
    chk("R8", low_power, 1'b1, "local events ignored");
    chk("R8", comwake_req | cominit_req, 1'b0, "no train from local events");

    phase = "R5"; pulse(1);
    chk("R3", comwake_req, 1'b1, "wake from low power");
    cyc(SEQ + TMO + 4);
    chk("R5", link_ready, 1'b0, "timeout back to listen");
    pulse(1);
    chk("R5", comwake_req, 1'b1, "listening after timeout");
    cyc(SEQ - 2); align_det = 1; cyc(2); align_det = 0;

    phase = "R9"; pulse(0);
    chk("R9", link_ready, 1'b0, "reset from ready");
    chk("R9", cominit_req, 1'b1, "init restarts");
    cyc(SEQ + 2);
    pulse(1); cyc(10); pulse(0);
    chk("R9", cominit_req, 1'b1, "reset mid wake train");
    cyc(SEQ + 2);

    phase = "R11"; pulse(3);
    chk("R11", cominit_req, 1'b1, "reset wins");
    chk("R11", comwake_req, 1'b0, "no wake train");
    cyc(SEQ + 2);

    phase = "R9"; bring_up(0); pulse(2); cyc(2); pulse(0);
    chk("R9", pmack_send, 1'b0, "reset during ack");
    cyc(SEQ + 2);
    bring_up(0); pulse(2); cyc(ACK + 2); pulse(0);
    chk("R9", low_power | tx_idle, 1'b0, "reset leaves low power");
    cyc(SEQ + 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule